// File: doc/BRIEF.md
# Nearest-Match Absolute-Difference Search Engine

The engine keeps a small bank of reference words and, on request, reports which of them lies numerically closest to a probe word. Each word is 16 bits wide. It is read as eight radix-4 digits, with the digit in bits [15:14] carrying the most weight and the digit in bits [1:0] the least. For every stored word, a digit-serial radix-4 borrow chain forms the difference between the probe and that word. The borrow out of the top digit gives the sign. When the sign is negative, every 2-bit digit code is inverted and one is added, so the distance is the exact magnitude. A scan over all distances then selects the smallest.

Software or a host loads references through a single-word write port. A one-cycle `start` pulse launches a search of the probe word on `inWord`. On the following cycle the engine raises `oValid` for one cycle. Alongside it come a one-hot flag of the winning word and that word's distance, and both stay on the outputs until the next search.

Top module: `nearest_match_engine`

## Requirements
- R1: While `rstN` is low, `oValid`, `oMatch` and `oDist` are zero and every stored reference word is cleared to 0. A search issued right after reset therefore reports word 0 with a distance equal to the probe value.
- R2: When `wrEn` is high at a rising clock edge, `wrData` replaces the reference word at index `wrIdx`, and later searches compare against the new value.
- R3: A search and a write in the same cycle compare against the bank contents from before that write.
- R4: `oValid` is high in the cycle that follows a rising edge at which `start` was high, and low in the cycle that follows an edge at which `start` was low.
- R5: After a search, `oDist` equals the smallest value of |probe − reference| over all stored words, computed as ordinary unsigned 16-bit integers.
- R6: After a search, `oMatch` has exactly one bit set, at the index of the word with the smallest distance. When several words tie, the lowest index wins.
- R7: In a cycle that follows an edge without `start`, `oMatch` and `oDist` keep their previous values.
- R8: A difference whose borrow runs through all eight digits is reported as the exact positive magnitude, up to 65535 (probe 0x0000 against reference 0xFFFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Load a reference word this cycle |
| wrIdx | input | $clog2(NUM_WORDS) | Index of the reference word to load |
| wrData | input | 2*DIGITS | Reference word value |
| start | input | 1 | Launch a search of `inWord` |
| inWord | input | 2*DIGITS | Probe word |
| oValid | output | 1 | One-cycle flag for a fresh search result |
| oMatch | output | NUM_WORDS | One-hot index of the nearest word |
| oDist | output | 2*DIGITS | Distance of the nearest word |

## Verification
The bench builds the engine with its default eight words of eight digits. At that size every reference index can be named directly, and the full 16-bit range is reachable. This makes the all-digit borrow case (0x0000 against 0xFFFF) and two-way and many-way ties directly reachable. An integer model, advanced on every clock, predicts the result of each search, including searches issued in the same cycle as a write and back-to-back searches. Several hundred random probes over random banks then exercise the borrow chain at every digit position.

// File: rtl/nm_pkg.sv
`timescale 1ns/1ps
package nm_pkg;
  // Strobes from control to datapath, one per action taken at an edge.
  typedef struct packed {
    logic capture;   // register the search result of the current probe
    logic load;      // write a reference word into the bank
  } nm_strobe_t;
endpackage

// File: rtl/nm_dist_unit.sv
`timescale 1ns/1ps
// Radix-4 borrow chain followed by a sign-controlled fold to magnitude.
module nm_dist_unit #(
  parameter int DIGITS = 8,
  localparam int WORD_W = 2 * DIGITS
) (
  input  logic [WORD_W-1:0] probeWord,
  input  logic [WORD_W-1:0] storedWord,
  output logic [WORD_W-1:0] distOut
);
  logic [DIGITS:0]     borrowChain;
  logic [WORD_W-1:0]   digitCodes;
  logic [WORD_W-1:0]   foldedCodes;
  logic                negFlag;

  assign borrowChain[0] = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [2:0] stepDiff;
    // a - b - borrowIn lies in -4..3; bit 2 marks a negative step
    assign stepDiff = {1'b0, probeWord[2*g+1 -: 2]}
                    - {1'b0, storedWord[2*g+1 -: 2]}
                    - {2'b00, borrowChain[g]};
    assign digitCodes[2*g+1 -: 2] = stepDiff[1:0];
    assign borrowChain[g+1]       = stepDiff[2];
  end

  assign negFlag = borrowChain[DIGITS];

  for (genvar g = 0; g < DIGITS; g++) begin : g_fold
    assign foldedCodes[2*g+1 -: 2] = negFlag ? ~digitCodes[2*g+1 -: 2]
                                             :  digitCodes[2*g+1 -: 2];
  end

  assign distOut = foldedCodes + {{(WORD_W-1){1'b0}}, negFlag};
endmodule

// File: rtl/nm_ctrl.sv
`timescale 1ns/1ps
module nm_ctrl
  import nm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       wrEn,
  output nm_strobe_t strobes,
  output logic       resultValid
);
  always_comb begin
    strobes.capture = start;
    strobes.load    = wrEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= start;
  end
endmodule

// File: rtl/nm_datapath.sv
`timescale 1ns/1ps
module nm_datapath
  import nm_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int DIGITS = 8,
  localparam int WORD_W = 2 * DIGITS,
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  nm_strobe_t           strobes,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [WORD_W-1:0]    wrData,
  input  logic [WORD_W-1:0]    inWord,
  output logic [NUM_WORDS-1:0] matchQ,
  output logic [WORD_W-1:0]    distQ
);
  logic [WORD_W-1:0]    bank    [NUM_WORDS];
  logic [WORD_W-1:0]    distVec [NUM_WORDS];
  logic [IDX_W-1:0]     bestIdx;
  logic [WORD_W-1:0]    bestDist;
  logic [NUM_WORDS-1:0] matchNext;

  // Reference bank
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_WORDS; k++) bank[k] <= '0;
    end else if (strobes.load) begin
      bank[wrIdx] <= wrData;
    end
  end

  // One distance unit per stored word
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    nm_dist_unit #(.DIGITS(DIGITS)) uDist (
      .probeWord (inWord),
      .storedWord(bank[w]),
      .distOut   (distVec[w])
    );
  end

  // Strict-less scan: earliest index keeps a tie
  always_comb begin
    bestIdx  = '0;
    bestDist = distVec[0];
    for (int k = 1; k < NUM_WORDS; k++) begin
      if (distVec[k] < bestDist) begin
        bestDist = distVec[k];
        bestIdx  = IDX_W'(k);
      end
    end
  end

  always_comb begin
    matchNext          = '0;
    matchNext[bestIdx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchQ <= '0;
      distQ  <= '0;
    end else if (strobes.capture) begin
      matchQ <= matchNext;
      distQ  <= bestDist;
    end
  end
endmodule

// File: rtl/nearest_match_engine.sv
`timescale 1ns/1ps
module nearest_match_engine
  import nm_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int DIGITS = 8,
  localparam int WORD_W = 2 * DIGITS,
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [WORD_W-1:0]    wrData,
  input  logic                 start,
  input  logic [WORD_W-1:0]    inWord,
  output logic                 oValid,
  output logic [NUM_WORDS-1:0] oMatch,
  output logic [WORD_W-1:0]    oDist
);
  nm_strobe_t strobes;

  nm_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .wrEn       (wrEn),
    .strobes    (strobes),
    .resultValid(oValid)
  );

  nm_datapath #(.NUM_WORDS(NUM_WORDS), .DIGITS(DIGITS)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wrIdx  (wrIdx),
    .wrData (wrData),
    .inWord (inWord),
    .matchQ (oMatch),
    .distQ  (oDist)
  );
endmodule

// File: rtl/nm_checker.sv
`timescale 1ns/1ps
module nm_checker #(
  parameter int NUM_WORDS = 8,
  parameter int WORD_W = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 start,
  input logic                 oValid,
  input logic [NUM_WORDS-1:0] oMatch,
  input logic [WORD_W-1:0]    oDist
);
  // R4: a launch is answered on the next cycle
  p_valid_after_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    start |=> oValid);

  // R4: no launch, no fresh result
  p_quiet_without_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !oValid);

  // R6: a reported result names exactly one word
  p_single_winner_r6: assert property (@(posedge clk) disable iff (!rstN)
    oValid |-> ($countones(oMatch) == 1));

  // R7: results hold while idle
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> ($stable(oMatch) && $stable(oDist)));
endmodule

bind nearest_match_engine nm_checker #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) uChk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .oValid(oValid),
  .oMatch(oMatch),
  .oDist (oDist)
);

// File: tb/sim_nearest_match_engine.sv
`timescale 1ns/1ps
module sim_nearest_match_engine;
  localparam int NW = 8;
  localparam int DG = 8;
  localparam int WW = 2 * DG;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [2:0]    wrIdx = '0;
  logic [WW-1:0] wrData = '0;
  logic          start = 1'b0;
  logic [WW-1:0] inWord = '0;
  logic          oValid;
  logic [NW-1:0] oMatch;
  logic [WW-1:0] oDist;

  int    testsRun = 0;
  int    testsFailed = 0;
  bit    armed = 0;
  bit    done = 0;
  string phaseTag = "R1";

  // Behavioural model state
  int       refMem [NW];
  bit       expValid = 0;
  bit [7:0] expMatch = '0;
  int       expDist = 0;

  always #2 clk = ~clk;  // 250 MHz

  nearest_match_engine #(.NUM_WORDS(NW), .DIGITS(DG)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .start(start), .inWord(inWord), .oValid(oValid), .oMatch(oMatch), .oDist(oDist)
  );

  // Model advanced at each rising edge; search reads bank before the write (R3)
  always @(posedge clk) begin
    armed <= 1;
    if (!rstN) begin
      for (int k = 0; k < NW; k++) refMem[k] = 0;
      expValid = 0; expMatch = '0; expDist = 0;
    end else begin
      expValid = start;
      if (start) begin
        int best;
        int bestD;
        best = 0;
        bestD = -1;
        for (int k = 0; k < NW; k++) begin
          int d;
          d = int'(inWord) - refMem[k];
          if (d < 0) d = -d;
          if (bestD < 0 || d < bestD) begin bestD = d; best = k; end
        end
        expMatch = '0;
        expMatch[best] = 1'b1;
        expDist = bestD;
      end
      if (wrEn) refMem[wrIdx] = int'(wrData);
    end
  end

  task automatic check(string tag, bit ok, int act, int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("[TB] FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // Compare away from the active edge
  always @(negedge clk) begin
    if (armed && !done) begin
      check({phaseTag, " valid(R4)"}, oValid == expValid, int'(oValid), int'(expValid));
      check({phaseTag, " match(R6)"}, oMatch == expMatch, int'(oMatch), int'(expMatch));
      check({phaseTag, " dist(R5)"},  int'(oDist) == expDist, int'(oDist), expDist);
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      wrEn = 0; start = 0;
    end
  endtask

  task automatic writeWord(int idx, int data);
    @(negedge clk);
    wrEn = 1; wrIdx = 3'(idx); wrData = WW'(data); start = 0;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic search(int probe);
    @(negedge clk);
    start = 1; inWord = WW'(probe); wrEn = 0;
    @(negedge clk);
    start = 0;
  endtask

  initial begin
    // R1: reset state, then a search over the cleared bank
    phaseTag = "R1";
    idle(3);
    rstN = 1;
    idle(2);
    search(16'h1234);
    idle(1);

    // R2: load the bank and search it
    phaseTag = "R2";
    writeWord(0, 16'h0000); writeWord(1, 16'hFFFF); writeWord(2, 16'h8000);
    writeWord(3, 16'h1234); writeWord(4, 16'h00FF); writeWord(5, 16'hABCD);
    writeWord(6, 16'h7FFF); writeWord(7, 16'h4000);
    search(16'hFFFF);
    search(16'h7FFF);

    // R5: assorted probes, exact and near
    phaseTag = "R5";
    search(16'h8001); search(16'h0100); search(16'hAB00); search(16'h3000);

    // R4: back-to-back launches
    phaseTag = "R4";
    @(negedge clk); start = 1; inWord = 16'h1235;
    @(negedge clk); inWord = 16'hABCE;
    @(negedge clk); inWord = 16'h00FE;
    @(negedge clk); start = 0;

    // R7: results hold across idle cycles
    phaseTag = "R7";
    idle(4);

    // R3: write and search in one cycle
    phaseTag = "R3";
    @(negedge clk); start = 1; inWord = 16'h5555; wrEn = 1; wrIdx = 3'd4; wrData = 16'h5555;
    @(negedge clk); start = 0; wrEn = 0;
    search(16'h5555);

    // R6: ties go to the lowest index
    phaseTag = "R6";
    writeWord(2, 16'h1000); writeWord(5, 16'h1010);
    search(16'h1008);
    writeWord(7, 16'h1234);
    search(16'h1234);
    for (int k = 0; k < NW; k++) writeWord(k, 16'h2222);
    search(16'h2000);

    // R8: borrow through every digit
    phaseTag = "R8";
    for (int k = 0; k < NW; k++) writeWord(k, 16'hFFFF);
    search(16'h0000);
    writeWord(3, 16'h0001);
    search(16'hFFFF);

    // R5: random banks and probes
    phaseTag = "R5";
    for (int r = 0; r < 40; r++) begin
      for (int k = 0; k < NW; k++) writeWord(k, int'($urandom_range(0, 65535)));
      for (int s = 0; s < 8; s++) search(int'($urandom_range(0, 65535)));
    end
    idle(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      testsRun++;
      testsFailed++;
      $display("[TB] FAIL watchdog expired in phase %s", phaseTag);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule